// File: doc/BRIEF.md
# Polled Serial Port with Bit-Level Transmit

This block is a serial port driven entirely by CPU polling through two I/O-mapped byte registers. A receiver turns an asynchronous 8N1 line into bytes. Its bit timing comes from counting a fixed number of CPU clocks per bit, 192 by default, so a 22.1184 MHz clock gives 115200 baud. A completed byte is held next to a ready flag. Software polls the flag in the status register and collects the byte from the data register; that read also clears the flag.

The transmit side has no shifter. Each write to the data register copies bit 0 of the written value straight to the TX pin, and software forms the frame by timing those writes. There are no handshake lines, no interrupt output and no buffering beyond the single held byte.

Top module: `poll_uart`

## Requirements
- R1: After reset, `tx_out` is 1, the ready flag is 0, and a read of the status address (default 0xF8) returns 0x00.
- R2: A received frame is one low start bit, 8 data bits sent least-significant bit first, then one high stop bit. A read of the data address (default 0xF9) returns the assembled byte.
- R3: The bit period is `CLKS_PER_BIT` clocks. A falling edge on the synchronized line is re-checked after `CLKS_PER_BIT/2` clocks. A low pulse shorter than that is dropped and sets no flag.
- R4: A good frame sets the ready flag, which reads as bit 0 of the status register. Status bits 7:1 always read 0.
- R5: A read of the data address clears the ready flag. A read of the status address leaves the flag unchanged.
- R6: A frame whose stop bit samples low is discarded. The flag and the held byte keep their previous values.
- R7: A good frame that completes while the flag is still set replaces the held byte, and the flag stays 1.
- R8: A write to the data address sets `tx_out` to bit 0 of `wdata`, and bits 7:1 have no effect. `tx_out` keeps that value until the next write to the data address.
- R9: A read of any address other than the two register addresses returns 0x00. A write to any other address leaves `tx_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; also the bit-timing reference |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | I/O address of the current access |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| tx_out | output | 1 | Serial transmit line, set by software |

## Verification
The bench sets `CLKS_PER_BIT` to 16, so a full frame takes 160 clocks. The default of 192 would take 1920. The shorter frame means the bench can afford many frames, including back-to-back frames with no read between them, frames with a bad stop bit, and start glitches timed against the half-bit re-check. The register addresses stay at their defaults of 0xF8 and 0xF9, so the bench also checks the address decode the software sees.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rx_byte_t;

    localparam int unsigned DATA_BITS = 8;

    function automatic logic [7:0] status_byte(input logic ready);
        return {7'b0, ready};
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign line_s = chain[STAGES-1];
    assign fall   = prev & ~line_s;

endmodule

// File: rtl/rx_engine.sv
module rx_engine
    import uart_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 192
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_s,
    input  logic     fall,
    output rx_byte_t rx_out
);
    localparam int unsigned CW = $clog2(CLKS_PER_BIT);
    localparam int unsigned HALF = CLKS_PER_BIT / 2;
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] BIT_LAST  = CW'(CLKS_PER_BIT - 1);
    localparam int unsigned BW = $clog2(DATA_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

    rx_state_e            state;
    logic [CW-1:0]        cnt;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            rx_out  <= '0;
        end else begin
            rx_out.valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (fall) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= line_s ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == BIT_LAST) begin
                        cnt     <= '0;
                        shreg   <= {line_s, shreg[DATA_BITS-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == LAST_BIT) state <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == BIT_LAST) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                        if (line_s) begin
                            rx_out.valid <= 1'b1;
                            rx_out.data  <= shreg;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R2
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_out.valid |=> !rx_out.valid);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= BIT_LAST);

    // R6
    stop_low_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_STOP && cnt == BIT_LAST && !line_s) |=> !rx_out.valid);

endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_byte_t   rx_in,
    input  logic       rd_clr,
    output logic       ready,
    output logic [7:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            held  <= '0;
        end else if (rx_in.valid) begin
            ready <= 1'b1;
            held  <= rx_in.data;
        end else if (rd_clr) begin
            ready <= 1'b0;
        end
    end

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !rx_in.valid) |=> !ready);

    // R7
    load_set_chk: assert property (@(posedge clk) disable iff (rst)
        rx_in.valid |=> (ready && held == $past(rx_in.data)));

    // R6
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_in.valid |=> $stable(held));

endmodule

// File: rtl/poll_uart.sv
module poll_uart
    import uart_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT = 192,
    parameter logic [7:0]  STATUS_ADDR  = 8'hF8,
    parameter logic [7:0]  DATA_ADDR    = 8'hF9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rx_in,
    output logic       tx_out
);
    localparam logic [7:0] TX_MASK = 8'h01;

    logic       line_s;
    logic       fall;
    rx_byte_t   rx_byte;
    logic       ready;
    logic [7:0] held;
    logic       sel_status;
    logic       sel_data;
    logic       rd_clr;

    rx_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_in(rx_in),
        .line_s (line_s),
        .fall   (fall)
    );

    rx_engine #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_engine (
        .clk   (clk),
        .rst   (rst),
        .line_s(line_s),
        .fall  (fall),
        .rx_out(rx_byte)
    );

    assign sel_status = (addr == STATUS_ADDR);
    assign sel_data   = (addr == DATA_ADDR);
    assign rd_clr     = rd_en & sel_data;

    rx_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_byte),
        .rd_clr(rd_clr),
        .ready (ready),
        .held  (held)
    );

    always_ff @(posedge clk) begin
        if (rst)                    tx_out <= 1'b1;
        else if (wr_en && sel_data) tx_out <= |(wdata & TX_MASK);
    end

    always_comb begin
        if (sel_status)    rdata = status_byte(ready);
        else if (sel_data) rdata = held;
        else               rdata = 8'h00;
    end

    // R8
    tx_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_data) |=> tx_out == $past(wdata[0]));

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel_data) |=> $stable(tx_out));

    // R4
    status_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_status) |-> rdata[7:1] == 7'b0);

    // R5
    status_read_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_status && ready) |=> ready);

endmodule

// File: tb/test_poll_uart.sv
module test_poll_uart;
    localparam int CLK_PERIOD = 10;
    localparam int BITCLK = 16;
    localparam logic [7:0] ST = 8'hF8;
    localparam logic [7:0] DT = 8'hF9;
    // bit 8 = stop bit good, bits 7:0 = byte
    localparam logic [8:0] VEC [8] = '{9'h155, 9'h1AA, 9'h100, 9'h1FF,
                                       9'h03C, 9'h181, 9'h0FF, 9'h17E};

    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] addr = 0;
    logic       rd_en = 0;
    logic       wr_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       rx_in = 1;
    logic       tx_out;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poll_uart #(.CLKS_PER_BIT(BITCLK)) i_poll_uart (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .rx_in(rx_in), .tx_out(tx_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 0; addr = 8'h00;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0; addr = 8'h00;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_ok);
        @(negedge clk);
        rx_in = 0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rx_in = stop_ok;
        repeat (BITCLK) @(negedge clk);
        rx_in = 1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] last_good;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        check("R1 tx idle", {7'b0, tx_out}, 8'h01);
        bus_read(ST, d);
        check("R1 status", d, 8'h00);
        last_good = 8'h00;

        // vector walk: R2 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            send_frame(VEC[v][7:0], VEC[v][8]);
            if (VEC[v][8]) begin
                bus_read(ST, d);
                check("R4 flag set", d, 8'h01);
                bus_read(ST, d);
                check("R5 status read keeps flag", d, 8'h01);
                bus_read(DT, d);
                check("R2 data", d, VEC[v][7:0]);
                last_good = VEC[v][7:0];
                bus_read(ST, d);
                check("R5 flag cleared", d, 8'h00);
            end else begin
                bus_read(ST, d);
                check("R6 bad stop no flag", d, 8'h00);
                bus_read(DT, d);
                check("R6 held byte kept", d, last_good);
            end
        end

        // R3: short start glitch is dropped
        @(negedge clk);
        rx_in = 0;
        repeat (BITCLK/2 - 3) @(negedge clk);
        rx_in = 1;
        repeat (3 * BITCLK) @(negedge clk);
        bus_read(ST, d);
        check("R3 glitch rejected", d, 8'h00);

        // R6: bad stop while flag set keeps both flag and byte
        send_frame(8'h3A, 1'b1);
        send_frame(8'hC5, 1'b0);
        bus_read(ST, d);
        check("R6 flag kept", d, 8'h01);
        bus_read(DT, d);
        check("R6 byte kept", d, 8'h3A);

        // R7: overwrite while flag set
        send_frame(8'h12, 1'b1);
        send_frame(8'h34, 1'b1);
        bus_read(ST, d);
        check("R7 flag stays", d, 8'h01);
        bus_read(DT, d);
        check("R7 newest byte", d, 8'h34);

        // R8: tx follows bit 0 only
        bus_write(DT, 8'hFE);
        check("R8 tx from FE", {7'b0, tx_out}, 8'h00);
        bus_write(DT, 8'h01);
        check("R8 tx from 01", {7'b0, tx_out}, 8'h01);
        bus_write(DT, 8'h00);
        check("R8 tx from 00", {7'b0, tx_out}, 8'h00);
        repeat (20) @(negedge clk);
        check("R8 tx holds", {7'b0, tx_out}, 8'h00);
        bus_write(DT, 8'hFF);
        check("R8 tx from FF", {7'b0, tx_out}, 8'h01);

        // R9: other addresses
        bus_write(ST, 8'h00);
        check("R9 status write no tx", {7'b0, tx_out}, 8'h01);
        bus_write(8'h10, 8'h00);
        check("R9 other write no tx", {7'b0, tx_out}, 8'h01);
        send_frame(8'h5A, 1'b1);
        bus_read(8'hFA, d);
        check("R9 other read zero", d, 8'h00);
        bus_read(ST, d);
        check("R9 other read no clear", d, 8'h01);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule